// File: doc/BRIEF.md
# Two-Request Event Sequencer

This block is a clocked model of a sequencing arbiter for transition-signalled handshakes. Two requesters each announce a request by toggling their own request wire. A separate token wire is toggled by the environment whenever it allows one more grant. For every token the block toggles exactly one grant wire. The grant goes to a requester whose request has been announced and not yet answered. Each requester alternates strictly between its request and its grant.

All three input wires arrive from outside the clock domain. Each passes through a synchronizer before its transitions are turned into single-cycle events. If a token arrives while nothing is pending, the block holds the token until a request appears. If both requests are pending when a token is used, the block grants one of them by a round-robin rule. The rule starts in favour of requester A after reset and flips after every contested grant. Protocol violations by the environment set a sticky error flag.

Top module: `evtSeqArbiter`

## Requirements
- R1: After reset both grant lines and the error flag are low.
- R2: With only request A pending, one token toggles grantA once and leaves grantB unchanged.
- R3: With only request B pending, one token toggles grantB once and leaves grantA unchanged.
- R4: Pending requests without a token produce no grant transition.
- R5: A token that arrives with no request pending is held. The next request to arrive is granted without a further token.
- R6: With both requests pending, a token produces exactly one grant. The first contested grant after reset goes to A, and later contested grants alternate between B and A.
- R7: An uncontested grant does not change which requester wins the next contested grant.
- R8: One token grants only one of two pending requests. The other stays pending and is granted by the next token.
- R9: A second transition on a request wire while that request is still pending sets the error flag. The extra transition creates no additional grant.
- R10: A second token transition while a held token is still waiting sets the error flag.
- R11: The error flag stays high once set until reset, and legal traffic never sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqA | input | 1 | Request A, each transition is one request |
| reqB | input | 1 | Request B, each transition is one request |
| nextTok | input | 1 | Token wire, each transition permits one grant |
| grantA | output | 1 | Grant for A, each transition is one grant |
| grantB | output | 1 | Grant for B, each transition is one grant |
| protoErr | output | 1 | Sticky protocol violation flag |

## Verification
The hardest state to reach from the ports is a contested grant that happens after an uncontested one. Reaching it shows that only contested grants move the round-robin priority. The stimulus first raises both requests before any token, so the pair is contested. It then spends a token on a lone A request, and raises both requests again. The expected winner at each step is fixed by R6 and R7. Error cases are driven from a fresh reset each time, so the sticky flag from one case cannot hide another.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  // Line indices inside the synchronizer bank
  localparam int LINE_A = 0;
  localparam int LINE_B = 1;
  localparam int LINE_N = 2;
  localparam int NUM_LINES = 3;

  typedef struct packed {
    logic grantA;    // toggle grant A this cycle
    logic grantB;    // toggle grant B this cycle
    logic flipPrio;  // contested grant, move round-robin pointer
    logic flagErr;   // protocol violation seen
    logic keepA;     // request A pending after this cycle
    logic keepB;     // request B pending after this cycle
    logic holdTok;   // token waiting after this cycle
  } seqStrobe_t;
endpackage

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl
  import evt_seq_pkg::*;
(
  input  logic       evtA,
  input  logic       evtB,
  input  logic       evtN,
  input  logic       pendA,
  input  logic       pendB,
  input  logic       tokHeld,
  input  logic       prioB,
  output seqStrobe_t strobe
);
  logic effA, effB, tokLive, bothPend, pickA, pickB;

  always_comb begin
    effA     = pendA | evtA;
    effB     = pendB | evtB;
    tokLive  = tokHeld | evtN;
    bothPend = effA & effB;
    pickA    = tokLive & effA & (~effB | ~prioB);
    pickB    = tokLive & effB & (~effA | prioB);

    strobe          = '0;
    strobe.grantA   = pickA;
    strobe.grantB   = pickB;
    strobe.flipPrio = tokLive & bothPend;
    strobe.flagErr  = (evtA & pendA) | (evtB & pendB) | (evtN & tokHeld);
    strobe.keepA    = effA & ~pickA;
    strobe.keepB    = effB & ~pickB;
    strobe.holdTok  = tokLive & ~(pickA | pickB);
  end
endmodule

// File: rtl/evt_seq_dp.sv
module evt_seq_dp
  import evt_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  seqStrobe_t strobe,
  output logic       evtA,
  output logic       evtB,
  output logic       evtN,
  output logic       pendA,
  output logic       pendB,
  output logic       tokHeld,
  output logic       prioB,
  output logic       grantA,
  output logic       grantB,
  output logic       protoErr
);
  localparam int CHAIN_LEN = SYNC_STAGES + 1;

  logic [NUM_LINES-1:0] evtVec;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic [CHAIN_LEN-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[CHAIN_LEN-2:0], lineIn[g]};
    end
    assign evtVec[g] = chain[CHAIN_LEN-1] ^ chain[CHAIN_LEN-2];
  end

  assign evtA = evtVec[LINE_A];
  assign evtB = evtVec[LINE_B];
  assign evtN = evtVec[LINE_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendA    <= 1'b0;
      pendB    <= 1'b0;
      tokHeld  <= 1'b0;
      prioB    <= 1'b0;
      grantA   <= 1'b0;
      grantB   <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      pendA   <= strobe.keepA;
      pendB   <= strobe.keepB;
      tokHeld <= strobe.holdTok;
      if (strobe.flipPrio) prioB  <= ~prioB;
      if (strobe.grantA)   grantA <= ~grantA;
      if (strobe.grantB)   grantB <= ~grantB;
      if (strobe.flagErr)  protoErr <= 1'b1;
    end
  end

  // R6 / R8: never two grants from one decision
  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    !(!$stable(grantA) && !$stable(grantB)));
  // R4: a grant transition needs a token in hand
  a_r4_grant_needs_token: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(grantA) || !$stable(grantB)) |-> $past(tokHeld || evtN));
  // R2: grant A needs request A outstanding
  a_r2_grant_a_pending: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(grantA) |-> $past(pendA || evtA));
  // R3: grant B needs request B outstanding
  a_r3_grant_b_pending: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(grantB) |-> $past(pendB || evtB));
  // R7: priority moves only when both requests were outstanding
  a_r7_prio_contested: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(prioB) |-> $past((pendA || evtA) && (pendB || evtB)));
  // R5: a held token means nothing is pending
  a_r5_held_idle: assert property (@(posedge clk) disable iff (!rstN)
    tokHeld |-> (!pendA && !pendB));
  // R11: error flag is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

// File: rtl/evtSeqArbiter.sv
module evtSeqArbiter
  import evt_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqA,
  input  logic reqB,
  input  logic nextTok,
  output logic grantA,
  output logic grantB,
  output logic protoErr
);
  seqStrobe_t strobe;
  logic evtA, evtB, evtN, pendA, pendB, tokHeld, prioB;
  logic [NUM_LINES-1:0] lineIn;

  always_comb begin
    lineIn         = '0;
    lineIn[LINE_A] = reqA;
    lineIn[LINE_B] = reqB;
    lineIn[LINE_N] = nextTok;
  end

  evt_seq_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strobe(strobe),
    .evtA(evtA), .evtB(evtB), .evtN(evtN),
    .pendA(pendA), .pendB(pendB), .tokHeld(tokHeld), .prioB(prioB),
    .grantA(grantA), .grantB(grantB), .protoErr(protoErr)
  );

  evt_seq_ctrl u_ctrl (
    .evtA(evtA), .evtB(evtB), .evtN(evtN),
    .pendA(pendA), .pendB(pendB), .tokHeld(tokHeld), .prioB(prioB),
    .strobe(strobe)
  );
endmodule

// File: tb/evtSeqArbiter_bench.sv
module evtSeqArbiter_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqA = 1'b0, reqB = 1'b0, nextTok = 1'b0;
  logic grantA, grantB, protoErr;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evtSeqArbiter u_evtSeqArbiter (
    .clk(clk), .rstN(rstN), .reqA(reqA), .reqB(reqB), .nextTok(nextTok),
    .grantA(grantA), .grantB(grantB), .protoErr(protoErr)
  );

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic chk(string req, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {gA,gB,err} actual=%b expected=%b", req, got, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {grantA, grantB, protoErr};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqA = 1'b0; reqB = 1'b0; nextTok = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
  endtask

  task automatic tA(); reqA = ~reqA; settle(); endtask
  task automatic tB(); reqB = ~reqB; settle(); endtask
  task automatic tN(); nextTok = ~nextTok; settle(); endtask

  task automatic testReset();
    doReset();
    chk("R1 reset", outs(), 3'b000);
  endtask

  task automatic testSingle();
    tA();
    chk("R4 request A without token", outs(), 3'b000);
    tN();
    chk("R2 lone A granted", outs(), 3'b100);
    tB();
    tN();
    chk("R3 lone B granted", outs(), 3'b110);
  endtask

  task automatic testHeld();
    tN();
    chk("R5 token held, no grant", outs(), 3'b110);
    tB();
    chk("R5 held token serves later B", outs(), 3'b100);
  endtask

  task automatic testContest();
    reqA = ~reqA; reqB = ~reqB; settle();
    chk("R4 both pending without token", outs(), 3'b100);
    tN();
    chk("R6 first contest goes to A", outs(), 3'b000);
    tN();
    chk("R8 second token serves remaining B", outs(), 3'b010);
  endtask

  task automatic testUncontested();
    tA(); tN();
    chk("R7 lone A grant", outs(), 3'b110);
    reqA = ~reqA; reqB = ~reqB; settle();
    tN();
    chk("R7 contest after lone grant goes to B", outs(), 3'b100);
    tN();
    chk("R8 remaining A granted", outs(), 3'b000);
    reqA = ~reqA; reqB = ~reqB; settle();
    tN();
    chk("R6 third contest goes back to A", outs(), 3'b100);
    tN();
    chk("R11 legal traffic leaves error low", outs(), 3'b110);
  endtask

  task automatic testTokErr();
    doReset();
    tN(); tN();
    chk("R10 second token while held", outs(), 3'b001);
    tA();
    chk("R11 error sticky, held token serves A", outs(), 3'b101);
    doReset();
    chk("R1 reset clears error", outs(), 3'b000);
  endtask

  task automatic testReqErr();
    tA(); tA();
    chk("R9 double request A flags error", outs(), 3'b001);
    tN();
    chk("R9 one grant for A", outs(), 3'b101);
    tN();
    chk("R9 extra request created no grant", outs(), 3'b101);
  endtask

  initial begin
    testReset();
    testSingle();
    testHeld();
    testContest();
    testUncontested();
    testTokErr();
    testReqErr();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule